// File: doc/BRIEF.md
# Timer Compare Output Unit

This block is one compare channel of a microcontroller-style timer peripheral. It holds a 16-bit compare value and checks it on every clock cycle against the count of one of two free-running timers. A select input picks the timer. When the chosen count first becomes equal to the compare value, a 4-bit mode field decides what happens to an output latch that drives a pin. The latch can be set, cleared, toggled, or left alone. A valid match also raises a sticky interrupt flag.

Software reaches the channel through a simple write port. Address 0 loads the compare value. Address 1 loads the control word, which holds the mode, the interrupt enable and the pin direction. Address 2 clears the flag. The pin is driven only while the direction bit selects output. The timers, the bus fabric and the pad are outside the block. The timer counts are taken to be in the block's clock domain.

Top module: `cmp_out_unit`

## Requirements
- R1: The comparator uses `tmr_a` when `tmr_sel` is 0 and `tmr_b` when `tmr_sel` is 1. The timer that is not selected never causes a match.
- R2: A match is the first cycle in which the selected count equals the compare value. While the two values stay equal, no further match occurs. A new match needs the equality to end and then begin again.
- R3: On a match, the output latch responds to the control bits [3:0] as follows: 4'b1000 sets it to 1, 4'b1001 clears it to 0, and 4'b0010 inverts it. The latch and flag outputs change at the clock edge where the match is seen.
- R4: In mode 4'b1010, a match sets the flag and leaves the output latch unchanged.
- R5: With any mode value other than 1000, 1001, 0010 or 1010, a match changes neither the latch nor the flag.
- R6: Every match in a valid mode sets `flag`. The flag stays set until a write to address 2 with data bit 0 = 1 clears it. If a match and a clear happen in the same cycle, the set wins.
- R7: `irq` is high exactly when `flag` is set and the interrupt-enable bit (control bit 4) is 1. Clearing the enable bit does not clear the flag.
- R8: A control write whose mode bits [3:0] are 0000 forces the output latch to 0. A control write with a nonzero mode leaves the latch as it was.
- R9: `pin_oe` equals the direction bit (control bit 5). `pin_out` shows the latch while that bit is 1 and is 0 otherwise. The latch keeps changing on matches even while the pin is not driven.
- R10: A write to address 0 loads `wr_data` as the compare value. A write to address 1 loads the control word. Both take effect at the next clock edge.
- R11: After reset, the compare value, the control word, the latch and the flag are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_a | input | 16 | Count of the first timer |
| tmr_b | input | 16 | Count of the second timer |
| tmr_sel | input | 1 | Timer select: 0 = tmr_a, 1 = tmr_b |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 compare, 1 control, 2 flag clear |
| wr_data | input | 16 | Register write data |
| pin_out | output | 1 | Pin data, gated by the direction bit |
| pin_oe | output | 1 | Pin output enable |
| irq | output | 1 | Interrupt request |
| flag | output | 1 | Sticky match flag |

## Verification
The timer counts are driven so that they step onto the compare value, stay on it across a flag clear, and then leave and come back. This separates edge detection from level detection. Each pin mode is run from a known latch state: toggle is applied twice to tell it apart from set or clear, and the interrupt-only mode and an unused mode start with the latch high so that "unchanged" is visible. Holding the other timer on the compare value while it is unselected, and then switching the select, shows that the selection is honoured. Clearing the control word and then re-enabling the pin, and setting the latch while the pin is an input, shows that the latch state is kept apart from the pin gating.

// File: rtl/cmp_out_unit.sv
module cmp_out_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] tmr_a,
  input  logic [W-1:0] tmr_b,
  input  logic         tmr_sel,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [15:0]  wr_data,
  output logic         pin_out,
  output logic         pin_oe,
  output logic         irq,
  output logic         flag
);

  localparam logic [3:0] M_HIGH = 4'b1000;
  localparam logic [3:0] M_LOW  = 4'b1001;
  localparam logic [3:0] M_TOG  = 4'b0010;
  localparam logic [3:0] M_INT  = 4'b1010;

  logic [W-1:0] cmp_q;
  logic [3:0]   mode_q;
  logic         ie_q, dir_q, latch_q, flag_q, eq_q;
  logic         latch_d, mode_ok;

  wire [W-1:0] tsel    = tmr_sel ? tmr_b : tmr_a;
  wire         eq      = (tsel == cmp_q);
  wire         hit     = eq & ~eq_q;
  wire         cmp_wr  = wr_en && (wr_addr == 2'd0);
  wire         ctrl_wr = wr_en && (wr_addr == 2'd1);
  wire         clr_wr  = wr_en && (wr_addr == 2'd2) && wr_data[0];

  always_comb begin
    mode_ok = (mode_q == M_HIGH) || (mode_q == M_LOW) ||
              (mode_q == M_TOG)  || (mode_q == M_INT);
    latch_d = latch_q;
    if (hit) begin
      case (mode_q)
        M_HIGH:  latch_d = 1'b1;
        M_LOW:   latch_d = 1'b0;
        M_TOG:   latch_d = ~latch_q;
        default: latch_d = latch_q;
      endcase
    end
    if (ctrl_wr && wr_data[3:0] == 4'd0) latch_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q   <= '0;
      mode_q  <= '0;
      ie_q    <= 1'b0;
      dir_q   <= 1'b0;
      latch_q <= 1'b0;
      flag_q  <= 1'b0;
      eq_q    <= 1'b0;
    end else begin
      eq_q    <= eq;
      latch_q <= latch_d;
      if (cmp_wr) cmp_q <= wr_data[W-1:0];
      if (ctrl_wr) begin
        mode_q <= wr_data[3:0];
        ie_q   <= wr_data[4];
        dir_q  <= wr_data[5];
      end
      if (hit && mode_ok)  flag_q <= 1'b1;
      else if (clr_wr)     flag_q <= 1'b0;
    end
  end

  assign flag    = flag_q;
  assign irq     = flag_q & ie_q;
  assign pin_oe  = dir_q;
  assign pin_out = latch_q & dir_q;

  assert_no_retrigger_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (eq_q && eq && !ctrl_wr) |=> $stable(latch_q));

  assert_flag_on_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mode_ok) |=> flag_q);

  assert_int_mode_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_INT && !ctrl_wr) |=> $stable(latch_q));

  assert_ctrl_zero_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wr_data[3:0] == 4'd0) |=> !latch_q);

  assert_bad_mode_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_ok && !flag_q && !ctrl_wr) |=> (!flag_q && $stable(latch_q)));

  assert_hold_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mode_q == M_HIGH && !ctrl_wr) |=> latch_q);

endmodule

// File: tb/sim_cmp_out_unit.sv
module sim_cmp_out_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] tmr_a = '0, tmr_b = '0, wr_data = '0;
  logic        tmr_sel = 1'b0, wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic        pin_out, pin_oe, irq, flag;

  int total = 0;
  int bad = 0;
  logic [3:0] q_val[$];
  string      q_tag[$];

  always #2 clk = ~clk;

  cmp_out_unit u0 (
    .clk(clk), .rst_n(rst_n), .tmr_a(tmr_a), .tmr_b(tmr_b), .tmr_sel(tmr_sel),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq), .flag(flag)
  );

  task automatic compare(input logic [3:0] exp, input string tag);
    logic [3:0] act;
    act = {pin_out, pin_oe, irq, flag};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: {pin,oe,irq,flag} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (q_val.size() > 0) compare(q_val.pop_front(), q_tag.pop_front());
  end

  task automatic step(input logic [15:0] ta, input logic [15:0] tb, input logic sel,
                      input logic we, input logic [1:0] addr, input logic [15:0] data,
                      input logic [3:0] exp, input string tag);
    @(negedge clk);
    tmr_a = ta; tmr_b = tb; tmr_sel = sel;
    wr_en = we; wr_addr = addr; wr_data = data;
    @(posedge clk);
    #1;
    q_val.push_back(exp);
    q_tag.push_back(tag);
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare(4'b0000, "R11 reset state");
    rst_n = 1'b1;
    // {pin,oe,irq,flag}; control: [3:0] mode, [4] irq enable, [5] direction
    step(16'h0, 16'h0, 0, 1, 2'd0, 16'h1234, 4'b0000, "R10 compare write");
    step(16'h0, 16'h0, 0, 1, 2'd1, 16'h0038, 4'b0100, "R9 oe follows direction");
    step(16'h1234, 16'h0, 0, 0, 2'd0, 16'h0, 4'b1111, "R3 set on match, R6 flag");
    step(16'h1234, 16'h0, 0, 1, 2'd2, 16'h1, 4'b1100, "R2 no retrigger while equal");
    step(16'h1235, 16'h0, 0, 0, 2'd0, 16'h0, 4'b1100, "R2 leave equality");
    step(16'h1235, 16'h0, 0, 1, 2'd1, 16'h0039, 4'b1100, "R8 nonzero mode keeps latch");
    step(16'h1234, 16'h0, 0, 0, 2'd0, 16'h0, 4'b0111, "R3 clear on match");
    step(16'h0, 16'h0, 0, 1, 2'd2, 16'h1, 4'b0100, "R6 flag clear");
    step(16'h0, 16'h0, 0, 1, 2'd1, 16'h0032, 4'b0100, "R10 control write");
    step(16'h1234, 16'h0, 0, 0, 2'd0, 16'h0, 4'b1111, "R3 toggle up");
    step(16'h0, 16'h0, 0, 0, 2'd0, 16'h0, 4'b1111, "R6 flag sticky");
    step(16'h1234, 16'h0, 0, 0, 2'd0, 16'h0, 4'b0111, "R3 toggle down");
    step(16'h0, 16'h0, 0, 0, 2'd0, 16'h0, 4'b0111, "R3 toggle idle");
    step(16'h1234, 16'h0, 0, 0, 2'd0, 16'h0, 4'b1111, "R3 toggle up again");
    step(16'h0, 16'h0, 0, 1, 2'd2, 16'h1, 4'b1100, "R6 flag clear");
    step(16'h0, 16'h0, 0, 1, 2'd1, 16'h002A, 4'b1100, "R7 enable off");
    step(16'h1234, 16'h0, 0, 0, 2'd0, 16'h0, 4'b1101, "R4 pin held, R7 irq masked");
    step(16'h1234, 16'h0, 0, 1, 2'd1, 16'h003A, 4'b1111, "R7 irq on enable");
    step(16'h1234, 16'h0, 0, 1, 2'd1, 16'h0039, 4'b1111, "R2 mode change no event");
    step(16'h0, 16'h1234, 0, 1, 2'd2, 16'h1, 4'b1100, "R1 unselected timer ignored");
    step(16'h0, 16'h1234, 1, 0, 2'd0, 16'h0, 4'b0111, "R1 second timer selected");
    step(16'h0, 16'h1234, 1, 1, 2'd2, 16'h1, 4'b0100, "R6 flag clear");
    step(16'h0, 16'h1234, 1, 1, 2'd1, 16'h0038, 4'b0100, "R10 control write");
    step(16'h0, 16'h0, 1, 0, 2'd0, 16'h0, 4'b0100, "R2 leave equality");
    step(16'h0, 16'h1234, 1, 0, 2'd0, 16'h0, 4'b1111, "R1 R3 set via second timer");
    step(16'h0, 16'h1234, 1, 1, 2'd2, 16'h1, 4'b1100, "R6 flag clear");
    step(16'h0, 16'h1234, 1, 1, 2'd1, 16'h0033, 4'b1100, "R5 unused mode write");
    step(16'h0, 16'h0, 1, 0, 2'd0, 16'h0, 4'b1100, "R5 leave equality");
    step(16'h0, 16'h1234, 1, 0, 2'd0, 16'h0, 4'b1100, "R5 no action no flag");
    step(16'h0, 16'h0, 1, 1, 2'd1, 16'h0000, 4'b0000, "R8 zero control");
    step(16'h0, 16'h0, 1, 1, 2'd1, 16'h0028, 4'b0100, "R8 latch was cleared");
    step(16'h0, 16'h0, 1, 1, 2'd1, 16'h0008, 4'b0000, "R9 direction input");
    step(16'h0, 16'h1234, 1, 0, 2'd0, 16'h0, 4'b0001, "R9 pin not driven");
    step(16'h0, 16'h1234, 1, 1, 2'd1, 16'h0028, 4'b1101, "R9 latch kept while input");
    step(16'h0, 16'h1234, 1, 1, 2'd2, 16'h1, 4'b1100, "R6 flag clear");
    step(16'h0, 16'h0, 1, 0, 2'd0, 16'h0, 4'b1100, "idle");
    @(negedge clk);
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule